// File: doc/BRIEF.md
# Half-Bridge PWM Stage

This block drives one half-bridge leg of a motor inverter. A free-running period counter, W bits wide, steps through 2^W clock ticks per PWM period and raises a one-cycle start pulse each time it wraps to zero. The counter value and the pulse leave the block so that sibling channels can share them. The channel itself has no counter. It compares the shared count against a duty word to produce a high-side drive and a complementary low-side drive.

The duty word and the two enables are written into shadow registers only on clock edges where `data_ok` is high. The upstream logic holds `data_ok` low while it assembles a new setting. The shadow contents move into the active setting only at the edge where the start pulse is high, so a period never sees two different settings. The `failsafe` input overrides everything and turns both transistors off.

Both drive outputs are registered. The outputs seen in the cycle where the count is c therefore reflect the comparison made against count c-1 (mod 2^W).

Top module: `hb_pwm_stage`

## Requirements
- R1: `cnt_out` increases by one on every clock after reset and returns from the all-ones value to 0, giving a period of 2^W cycles.
- R2: `sync_out` is 1 exactly in the cycles where `cnt_out` is 0 after a wrap, and 0 in every other cycle. It is also 0 directly after reset.
- R3: When `en_hi` is set, no failsafe is pending and p is the previous count, `(cnt_out - 1) mod 2^W`, `drv_hi` is 1 exactly when p < duty. When `en_hi` is clear, `drv_hi` is 0.
- R4: A duty of 0 keeps `drv_hi` at 0 for the whole period. A duty of all-ones gives 2^W-1 high cycles per period.
- R5: `drv_lo` is 1 exactly when `en_lo` is set, no failsafe is pending and p >= duty, using the same p as R3. When `en_lo` is clear, `drv_lo` is 0.
- R6: If `failsafe` is 1 at a clock edge, both `drv_hi` and `drv_lo` are 0 after that edge, whatever the enables and duty are. Normal drive resumes one edge after `failsafe` returns to 0.
- R7: Duty and enables are captured only at edges where `data_ok` is 1. Changes made while `data_ok` is 0 have no effect on the outputs.
- R8: A captured setting takes effect only at the edge where `sync_out` is 1. A capture in mid-period leaves the rest of that period on the old setting, and the new setting governs outputs from the slot of count 0 onward.
- R9: A synchronous `rst` clears the counter, `sync_out`, the shadow and active settings and both outputs. After reset, with no capture, both outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_ok | input | 1 | Setting inputs are consistent and may be captured |
| failsafe | input | 1 | Forces both drives off |
| en_hi | input | 1 | Enable for the high-side drive |
| en_lo | input | 1 | Enable for the low-side drive |
| duty | input | W | Count at which the drive swaps from high-side to low-side |
| cnt_out | output | W | Shared period count |
| sync_out | output | 1 | One-cycle period-start pulse |
| drv_hi | output | 1 | High-side drive |
| drv_lo | output | 1 | Complementary low-side drive |

## Verification
The hardest case to reach is a capture that lands in the middle of a period, where the shadow already holds the new setting but the outputs must still follow the old one until the next wrap. The bench waits for a chosen mid-period count, pulses `data_ok` with a very different duty, and checks the remaining slots against the old duty before it checks the next period against the new one. Around this, a 4-bit counter is used to sweep every duty value against every enable pair. Each slot is checked against the arithmetic comparison of the previous count, and each period's high and low totals are checked as well.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;

    // Enable pair for one half-bridge leg.
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    // Resolve both drives from the enable pair, the compare result and failsafe.
    function automatic gate_t resolve_drive(logic fs, gate_t g, logic on_phase);
        gate_t r;
        r.hi = !fs && g.hi && on_phase;
        r.lo = !fs && g.lo && !on_phase;
        return r;
    endfunction

endpackage

// File: rtl/hbpwm_period_gen.sv
module hbpwm_period_gen #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count_o,
    output logic         sync_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         sync;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_MAX) begin
            st_d.cnt  = '0;
            st_d.sync = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.sync = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign sync_o  = st_q.sync;

    // R1: the count steps by one unless it sits at the top.
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1));

    // R1: the top value is followed by zero.
    a_r1_count_wrap: assert property (@(posedge clk) disable iff (rst)
        (count_o == CNT_MAX) |=> (count_o == '0));

    // R2: the start pulse only appears with a zero count.
    a_r2_sync_at_zero: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> (count_o == '0));

endmodule

// File: rtl/hbpwm_settings.sv
module hbpwm_settings
    import hbpwm_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         apply_i,
    input  logic [W-1:0] duty_i,
    input  gate_t        gate_i,
    output logic [W-1:0] duty_next_o,
    output gate_t        gate_next_o
);
    typedef struct packed {
        logic [W-1:0] sh_duty;
        gate_t        sh_gate;
        logic [W-1:0] act_duty;
        gate_t        act_gate;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // R7: the shadow copy is taken only while the inputs are marked consistent.
        if (load_i) begin
            st_d.sh_duty = duty_i;
            st_d.sh_gate = gate_i;
        end
        // R8: the active copy moves only at the period start.
        if (apply_i) begin
            st_d.act_duty = st_q.sh_duty;
            st_d.act_gate = st_q.sh_gate;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Look-ahead view, so the count-0 slot already uses the new setting.
    assign duty_next_o = st_d.act_duty;
    assign gate_next_o = st_d.act_gate;

    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(st_q.sh_duty) && $stable(st_q.sh_gate)));

    a_r8_active_hold: assert property (@(posedge clk) disable iff (rst)
        !apply_i |=> ($stable(st_q.act_duty) && $stable(st_q.act_gate)));

endmodule

// File: rtl/hbpwm_drive.sv
module hbpwm_drive
    import hbpwm_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] duty_i,
    input  gate_t        gate_i,
    input  logic         failsafe_i,
    output logic         hi_o,
    output logic         lo_o
);
    gate_t out_d, out_q;
    logic  on_phase;

    always_comb begin
        on_phase = (count_i < duty_i);
        out_d    = resolve_drive(failsafe_i, gate_i, on_phase);
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign hi_o = out_q.hi;
    assign lo_o = out_q.lo;

    // R6: failsafe clears both drives at the next edge.
    a_r6_failsafe_off: assert property (@(posedge clk) disable iff (rst)
        failsafe_i |=> (!hi_o && !lo_o));

    // R4: a zero duty never raises the high side.
    a_r4_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (duty_i == '0) |=> !hi_o);

    // R5: a cleared low-side enable keeps the low side off.
    a_r5_lo_gated: assert property (@(posedge clk) disable iff (rst)
        !gate_i.lo |=> !lo_o);

    // R3: a cleared high-side enable keeps the high side off.
    a_r3_hi_gated: assert property (@(posedge clk) disable iff (rst)
        !gate_i.hi |=> !hi_o);

endmodule

// File: rtl/hb_pwm_stage.sv
module hb_pwm_stage
    import hbpwm_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         data_ok,
    input  logic         failsafe,
    input  logic         en_hi,
    input  logic         en_lo,
    input  logic [W-1:0] duty,
    output logic [W-1:0] cnt_out,
    output logic         sync_out,
    output logic         drv_hi,
    output logic         drv_lo
);
    logic [W-1:0] duty_next;
    gate_t        gate_in;
    gate_t        gate_next;

    assign gate_in.hi = en_hi;
    assign gate_in.lo = en_lo;

    hbpwm_period_gen #(.W(W)) u_period (
        .clk     (clk),
        .rst     (rst),
        .count_o (cnt_out),
        .sync_o  (sync_out)
    );

    hbpwm_settings #(.W(W)) u_settings (
        .clk         (clk),
        .rst         (rst),
        .load_i      (data_ok),
        .apply_i     (sync_out),
        .duty_i      (duty),
        .gate_i      (gate_in),
        .duty_next_o (duty_next),
        .gate_next_o (gate_next)
    );

    hbpwm_drive #(.W(W)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .count_i    (cnt_out),
        .duty_i     (duty_next),
        .gate_i     (gate_next),
        .failsafe_i (failsafe),
        .hi_o       (drv_hi),
        .lo_o       (drv_lo)
    );

    // R5: the two drives are never on together at the stage boundary.
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drv_hi && drv_lo));

endmodule

// File: tb/hb_pwm_stage_test.sv
module hb_pwm_stage_test;
    localparam int W = 4;
    localparam int N = 1 << W;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_ok = 1'b0;
    logic failsafe = 1'b0;
    logic en_hi = 1'b0;
    logic en_lo = 1'b0;
    logic [W-1:0] duty = '0;
    logic [W-1:0] cnt_out;
    logic sync_out, drv_hi, drv_lo;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    hb_pwm_stage #(.W(W)) uut (
        .clk(clk), .rst(rst), .data_ok(data_ok), .failsafe(failsafe),
        .en_hi(en_hi), .en_lo(en_lo), .duty(duty),
        .cnt_out(cnt_out), .sync_out(sync_out), .drv_hi(drv_hi), .drv_lo(drv_lo)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(int m, bit eh, bit el);
        duty = W'(m); en_hi = eh; en_lo = el; data_ok = 1'b1;
        tick();
        data_ok = 1'b0;
    endtask

    task automatic wait_start();
        while (sync_out !== 1'b1) tick();
    endtask

    // Checks one full period that begins with the current negedge at count 0.
    task automatic check_period(int m, bit eh, bit el, bit fs, string tag);
        int hic = 0;
        int loc = 0;
        int prev = int'(cnt_out);
        for (int k = 0; k < N; k++) begin
            int c;
            int p;
            tick();
            c = int'(cnt_out);
            p = (c + N - 1) % N;
            chk("R1", "count step", c, (prev + 1) % N);
            chk("R2", "sync", int'(sync_out), (c == 0) ? 1 : 0);
            if (fs) begin
                chk("R6", "hi under failsafe", int'(drv_hi), 0);
                chk("R6", "lo under failsafe", int'(drv_lo), 0);
            end else begin
                chk("R3", "hi slot", int'(drv_hi), (eh && p < m) ? 1 : 0);
                chk("R5", "lo slot", int'(drv_lo), (el && p >= m) ? 1 : 0);
            end
            hic += int'(drv_hi);
            loc += int'(drv_lo);
            prev = c;
        end
        chk(tag, "hi total", hic, (fs || !eh) ? 0 : m);
        chk(tag, "lo total", loc, (fs || !el) ? 0 : N - m);
    endtask

    initial begin
        wait (cyc >= LIMIT);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) tick();
        chk("R9", "count in reset", int'(cnt_out), 0);
        chk("R9", "sync in reset", int'(sync_out), 0);
        chk("R9", "hi in reset", int'(drv_hi), 0);
        chk("R9", "lo in reset", int'(drv_lo), 0);
        rst = 1'b0;
        wait_start();
        check_period(0, 1'b0, 1'b0, 1'b0, "R9");

        // Sweep every duty against every enable pair (R3, R4, R5).
        for (int m = 0; m < N; m++) begin
            for (int e = 0; e < 4; e++) begin
                load(m, e[1], e[0]);
                wait_start();
                check_period(m, e[1], e[0], 1'b0, (m == 0 || m == N - 1) ? "R4" : "R3");
            end
        end

        // R7: changes without data_ok are ignored over two periods.
        duty = W'(3); en_hi = 1'b0; en_lo = 1'b0;
        wait_start();
        check_period(N - 1, 1'b1, 1'b1, 1'b0, "R7");
        check_period(N - 1, 1'b1, 1'b1, 1'b0, "R7");

        // R8: a mid-period capture waits for the next period start.
        load(2, 1'b1, 1'b0);
        wait_start();
        check_period(2, 1'b1, 1'b0, 1'b0, "R8");
        while (cnt_out != W'(6)) tick();
        load(13, 1'b1, 1'b1);
        while (sync_out !== 1'b1) begin
            int p;
            p = (int'(cnt_out) + N - 1) % N;
            chk("R8", "old hi held", int'(drv_hi), (p < 2) ? 1 : 0);
            chk("R8", "old lo held", int'(drv_lo), 0);
            tick();
        end
        chk("R8", "hi at wrap slot", int'(drv_hi), 0);
        chk("R8", "lo at wrap slot", int'(drv_lo), 0);
        check_period(13, 1'b1, 1'b1, 1'b0, "R8");

        // R6: failsafe in mid-period, then release.
        while (cnt_out != W'(4)) tick();
        failsafe = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick();
            chk("R6", "hi forced off", int'(drv_hi), 0);
            chk("R6", "lo forced off", int'(drv_lo), 0);
        end
        failsafe = 1'b0;
        tick();
        begin
            int p;
            p = (int'(cnt_out) + N - 1) % N;
            chk("R6", "hi after release", int'(drv_hi), (p < 13) ? 1 : 0);
            chk("R6", "lo after release", int'(drv_lo), (p >= 13) ? 1 : 0);
        end
        wait_start();
        failsafe = 1'b1;
        check_period(13, 1'b1, 1'b1, 1'b1, "R6");
        failsafe = 1'b0;

        // R9: reset in mid-run clears the settings too.
        tick(); tick();
        rst = 1'b1;
        tick(); tick();
        chk("R9", "count after reset", int'(cnt_out), 0);
        chk("R9", "sync after reset", int'(sync_out), 0);
        chk("R9", "hi after reset", int'(drv_hi), 0);
        chk("R9", "lo after reset", int'(drv_lo), 0);
        rst = 1'b0;
        wait_start();
        check_period(13, 1'b0, 1'b0, 1'b0, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule